// File: doc/BRIEF.md
# Two-Bank Edge-Triggered Interrupt Line Controller

This block gathers up to forty interrupt lines into two register banks: a full 32-line bank and an 8-line bank. Sixteen of the lines are driven from external level inputs, which the block samples every clock. When an input changes in the polarity chosen for its line, the block latches a pending flag and emits a one-cycle pulse on that line's output. Software can also raise a line through a software trigger register. It clears a pending flag by writing a one to it.

Some lines are fixed, or "direct", lines. Their trigger and pending bits cannot be written, and their mask bits come out of reset already set. A simple word bus gives access to the registers. A write takes effect on the clock edge where the write strobe is sampled. Read data is registered and is valid from the cycle after the read strobe.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, the mask register of bank 0 reads 0xFF820000 and that of bank 1 reads 0x00000087. Every other register reads zero and every interrupt output is low.
- R2: Registers sit at offset bank*0x20 + 4*k, with k = 0 mask, 1 event mask, 2 rising select, 3 falling select, 4 software trigger, 5 pending. Read data appears one cycle after the read strobe. An unaligned offset, an offset with k > 5, or an offset in a bank that does not exist reads as zero, and a write to it changes nothing.
- R3: The mask and event mask registers keep every written bit that belongs to an existing line (bank 1: bits 7:0 only). The rising select, falling select, software trigger and pending registers also drop the direct-line bits, which are bank 0 0xFF820000 and bank 1 0x00000087.
- R4: An input edge on a line whose mask bit is 0 produces no pulse and sets no pending bit.
- R5: On a line with its mask bit set, a rising input edge with rising select set, or a falling edge with falling select set, raises that line's output for exactly one cycle and sets its pending bit. The pulse appears in the cycle after the clock edge that first samples the new input level. An edge of the unselected polarity does nothing.
- R6: A software trigger write fires line i when bit i goes from 0 to 1, mask bit i is 1 and pending bit i is 0. The line pulses once in the cycle after the write and its pending bit is set. The register then holds the written value, with R3 masking applied.
- R7: A software trigger bit that is already 1, or a line whose mask bit is 0, or a line that is already pending, produces no pulse on a software trigger write.
- R8: Writing 1 to a pending bit clears it and also clears the matching software trigger bit. A 0 written to a pending bit has no effect.
- R9: A hardware edge and a software trigger on one line in the same cycle produce a single one-cycle pulse. If a new event and a pending clear meet on one line in the same cycle, the pending bit ends up set.
- R10: Lines 32 to 39 map to bits 0 to 7 of bank 1 and pulse outputs 32 to 39.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the accessed register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| extIn | input | 16 | External level inputs for lines 0 to 15 |
| irqOut | output | 40 | One-cycle interrupt pulse for each line |

## Verification
Every result of this block is due one clock after its cause. A register write shows up in a read issued afterwards, and read data lands on the edge that samples the read strobe. A pulse from an input change or a software trigger is high during the cycle that follows the sampling edge, and low the cycle after that.

The bench drives on falling edges and samples on the next falling edge, which puts each check exactly one rising edge after its stimulus. A monitor counts output pulses 2 ns after each rising edge. Single-pulse and no-pulse checks compare that count over a window that closes several cycles after the stimulus.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int BANK_W = 32;

  typedef enum logic [2:0] {
    SEL_MASK   = 3'd0,
    SEL_EVMASK = 3'd1,
    SEL_RISE   = 3'd2,
    SEL_FALL   = 3'd3,
    SEL_SWTRIG = 3'd4,
    SEL_PEND   = 3'd5,
    SEL_NONE   = 3'd7
  } regSel_e;

  // strobes from the bus decoder to the register datapath
  typedef struct packed {
    logic    wrMask;
    logic    wrEvMask;
    logic    wrRise;
    logic    wrFall;
    logic    wrSwTrig;
    logic    wrPend;
    logic    rdLoad;
    regSel_e rdSel;
    logic [2:0] bank;
  } irqcStrobe_t;

endpackage

// File: rtl/irqc_bus_ctrl.sv
module irqc_bus_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  addr,
  output irqcStrobe_t strb
);

  logic [2:0] bankIdx;
  logic [2:0] regIdx;
  logic       aligned;
  logic       known;

  assign bankIdx = addr[7:5];
  assign regIdx  = addr[4:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign known   = aligned && (int'(bankIdx) < NUM_BANKS) && (regIdx <= 3'd5);

  always_comb begin
    strb          = '0;
    strb.bank     = bankIdx;
    strb.rdLoad   = rdEn;
    strb.rdSel    = known ? regSel_e'(regIdx) : SEL_NONE;
    strb.wrMask   = wrEn && known && (regIdx == 3'd0);
    strb.wrEvMask = wrEn && known && (regIdx == 3'd1);
    strb.wrRise   = wrEn && known && (regIdx == 3'd2);
    strb.wrFall   = wrEn && known && (regIdx == 3'd3);
    strb.wrSwTrig = wrEn && known && (regIdx == 3'd4);
    strb.wrPend   = wrEn && known && (regIdx == 3'd5);
  end

  // R2: at most one register is written per access, never on an unaligned offset
  assert_one_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrMask, strb.wrEvMask, strb.wrRise, strb.wrFall,
              strb.wrSwTrig, strb.wrPend}));

  assert_unaligned_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (addr[1:0] != 2'b00) |-> (strb.rdSel == SEL_NONE &&
      $countones({strb.wrMask, strb.wrEvMask, strb.wrRise, strb.wrFall,
                  strb.wrSwTrig, strb.wrPend}) == 0));

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int          NUM_LINES   = 40,
  parameter int          NUM_EXT     = 16,
  parameter logic [63:0] DIRECT_MASK = 64'h00000087_FF820000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  irqcStrobe_t          strb,
  input  logic [31:0]          wrData,
  input  logic [NUM_EXT-1:0]   extIn,
  output logic [31:0]          rdData,
  output logic [NUM_LINES-1:0] irqOut
);

  localparam int NUM_BANKS = (NUM_LINES + BANK_W - 1) / BANK_W;
  localparam int PAD_W     = NUM_BANKS * BANK_W;
  localparam logic [NUM_LINES-1:0] DIRECT = DIRECT_MASK[NUM_LINES-1:0];
  localparam logic [NUM_LINES-1:0] CFG    = ~DIRECT;

  logic [NUM_LINES-1:0] maskReg, evMaskReg, riseReg, fallReg, swReg, pendReg;
  logic [NUM_EXT-1:0]   inPrev;

  // spread the written word over all banks, then keep the addressed bank
  logic [PAD_W-1:0]     wrSpread, hitPad;
  logic [NUM_LINES-1:0] hitLines, wrLines;

  assign wrSpread = {NUM_BANKS{wrData}};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bankHit
    assign hitPad[b*BANK_W +: BANK_W] = {BANK_W{(strb.bank == 3'(b))}};
  end

  assign hitLines = hitPad[NUM_LINES-1:0];
  assign wrLines  = wrSpread[NUM_LINES-1:0] & hitLines;

  // edge detection on the external inputs
  logic [NUM_EXT-1:0]   riseExt, fallExt;
  logic [NUM_LINES-1:0] riseLines, fallLines;

  assign riseExt   = extIn & ~inPrev;
  assign fallExt   = ~extIn & inPrev;
  assign riseLines = NUM_LINES'(riseExt);
  assign fallLines = NUM_LINES'(fallExt);

  logic [NUM_LINES-1:0] hwFire, swFire, fire, pendClr;

  assign hwFire  = maskReg & ((riseLines & riseReg) | (fallLines & fallReg));
  assign swFire  = strb.wrSwTrig ? (wrLines & CFG & ~swReg & maskReg & ~pendReg) : '0;
  assign fire    = hwFire | swFire;
  assign pendClr = strb.wrPend ? (wrLines & CFG & pendReg) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg   <= DIRECT;
      evMaskReg <= '0;
      riseReg   <= '0;
      fallReg   <= '0;
      swReg     <= '0;
      pendReg   <= '0;
      irqOut    <= '0;
      inPrev    <= extIn;
    end else begin
      inPrev <= extIn;
      irqOut <= fire;
      if (strb.wrMask)   maskReg   <= (maskReg & ~hitLines) | wrLines;
      if (strb.wrEvMask) evMaskReg <= (evMaskReg & ~hitLines) | wrLines;
      if (strb.wrRise)   riseReg   <= (riseReg & ~hitLines) | (wrLines & CFG);
      if (strb.wrFall)   fallReg   <= (fallReg & ~hitLines) | (wrLines & CFG);
      if (strb.wrSwTrig)    swReg <= (swReg & ~hitLines) | (wrLines & CFG);
      else if (strb.wrPend) swReg <= swReg & ~pendClr;
      // a new event wins over a clear in the same cycle
      pendReg <= (pendReg & ~pendClr) | fire;
    end
  end

  // registered read-back
  logic [NUM_LINES-1:0] selLines;
  logic [PAD_W-1:0]     selPad;
  logic [31:0]          rdWord;

  always_comb begin
    unique case (strb.rdSel)
      SEL_MASK:   selLines = maskReg;
      SEL_EVMASK: selLines = evMaskReg;
      SEL_RISE:   selLines = riseReg;
      SEL_FALL:   selLines = fallReg;
      SEL_SWTRIG: selLines = swReg;
      SEL_PEND:   selLines = pendReg;
      default:    selLines = '0;
    endcase
  end

  assign selPad = PAD_W'(selLines);
  assign rdWord = (int'(strb.bank) < NUM_BANKS) ? selPad[int'(strb.bank)*BANK_W +: BANK_W] : 32'h0;

  always_ff @(posedge clk) begin
    if (!rstN)            rdData <= '0;
    else if (strb.rdLoad) rdData <= rdWord;
  end

  // R1: reset state of masks, pending flags and outputs
  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |=> (maskReg == DIRECT && pendReg == '0 && irqOut == '0));

  // R3: direct lines never hold trigger, software or pending bits
  assert_direct_locked_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((riseReg | fallReg | swReg | pendReg) & DIRECT) == '0);

  // R4: a pending bit only rises on a line that was unmasked
  assert_mask_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pendReg & ~$past(pendReg) & ~$past(maskReg)) == '0);

  // R5: every pulse leaves its pending flag set
  assert_pulse_pend_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut & ~pendReg) == '0);

  // R7: a line already pending is never pulsed by software
  assert_sw_pend_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut & $past(pendReg) & ~$past(hwFire)) == '0);

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int          NUM_LINES   = 40,
  parameter int          NUM_EXT     = 16,
  parameter logic [63:0] DIRECT_MASK = 64'h00000087_FF820000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [7:0]           addr,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdData,
  input  logic [NUM_EXT-1:0]   extIn,
  output logic [NUM_LINES-1:0] irqOut
);

  localparam int NUM_BANKS = (NUM_LINES + BANK_W - 1) / BANK_W;

  irqcStrobe_t strb;

  irqc_bus_ctrl #(
    .NUM_BANKS(NUM_BANKS)
  ) ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  irqc_datapath #(
    .NUM_LINES  (NUM_LINES),
    .NUM_EXT    (NUM_EXT),
    .DIRECT_MASK(DIRECT_MASK)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .extIn  (extIn),
    .rdData (rdData),
    .irqOut (irqOut)
  );

endmodule

// File: tb/edge_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module edge_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [15:0] extIn = '0;
  logic [39:0] irqOut;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  edge_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .extIn(extIn), .irqOut(irqOut)
  );

  always @(posedge clk) begin
    #2;
    pulses += $countones(irqOut);
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic readCheck(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    busRead(a, d);
    check(req, $sformatf("read 0x%02h", a), 64'(d), 64'(exp));
  endtask

  task automatic driveIn(int idx, logic v);
    @(negedge clk);
    extIn[idx] = v;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "outputs after reset", 64'(irqOut), 64'h0);
    readCheck("R1", 8'h00, 32'hFF82_0000);
    readCheck("R1", 8'h20, 32'h0000_0087);
    readCheck("R1", 8'h08, 32'h0);
    readCheck("R1", 8'h14, 32'h0);
    readCheck("R1", 8'h30, 32'h0);
  endtask

  task automatic t_masking();
    busWrite(8'h08, 32'hFFFF_FFFF);
    readCheck("R3", 8'h08, 32'h007D_FFFF);
    busWrite(8'h28, 32'hFFFF_FFFF);
    readCheck("R3", 8'h28, 32'h0000_0078);
    busWrite(8'h20, 32'hFFFF_FFFF);
    readCheck("R3", 8'h20, 32'h0000_00FF);
    busWrite(8'h04, 32'hFFFF_FFFF);
    readCheck("R3", 8'h04, 32'hFFFF_FFFF);
    busWrite(8'h08, 32'h0);
    busWrite(8'h28, 32'h0);
  endtask

  task automatic t_decode();
    readCheck("R2", 8'h18, 32'h0);
    readCheck("R2", 8'h03, 32'h0);
    busWrite(8'h02, 32'h0000_FFFF);
    readCheck("R2", 8'h00, 32'hFF82_0000);
    busWrite(8'h48, 32'hFFFF_FFFF);
    readCheck("R2", 8'h48, 32'h0);
  endtask

  task automatic t_hwEdge();
    int snap;
    busWrite(8'h00, 32'hFFFF_FFFF);
    busWrite(8'h08, 32'h0000_0001);
    busWrite(8'h0C, 32'h0000_0002);
    driveIn(0, 1'b1);
    check("R5", "rise pulse line0", 64'(irqOut), 64'h1);
    idle(1);
    check("R5", "pulse one cycle", 64'(irqOut), 64'h0);
    readCheck("R5", 8'h14, 32'h1);
    snap = pulses;
    driveIn(0, 1'b0);
    driveIn(1, 1'b1);
    idle(3);
    check("R5", "unselected polarity quiet", 64'(pulses - snap), 64'd0);
    driveIn(1, 1'b0);
    check("R5", "fall pulse line1", 64'(irqOut), 64'h2);
    readCheck("R5", 8'h14, 32'h3);
  endtask

  task automatic t_maskGate();
    int snap;
    busWrite(8'h08, 32'h0000_0005);
    busWrite(8'h00, 32'hFFFF_FFFB);
    snap = pulses;
    driveIn(2, 1'b1);
    check("R4", "masked line no pulse", 64'(irqOut), 64'h0);
    idle(3);
    check("R4", "masked pulse count", 64'(pulses - snap), 64'd0);
    readCheck("R4", 8'h14, 32'h3);
    busWrite(8'h00, 32'hFFFF_FFFF);
    driveIn(2, 1'b0);
  endtask

  task automatic t_pendClear();
    busWrite(8'h14, 32'h0);
    readCheck("R8", 8'h14, 32'h3);
    busWrite(8'h14, 32'h1);
    readCheck("R8", 8'h14, 32'h2);
    busWrite(8'h14, 32'hFFFF_FFFF);
    readCheck("R8", 8'h14, 32'h0);
  endtask

  task automatic t_swTrig();
    busWrite(8'h10, 32'h0010_0000);
    check("R6", "software pulse line20", 64'(irqOut), 64'h10_0000);
    idle(1);
    check("R6", "software pulse ends", 64'(irqOut), 64'h0);
    readCheck("R6", 8'h14, 32'h0010_0000);
    readCheck("R6", 8'h10, 32'h0010_0000);
  endtask

  task automatic t_swBlock();
    int snap;
    snap = pulses;
    busWrite(8'h10, 32'h0010_0000);
    idle(3);
    check("R7", "bit already set", 64'(pulses - snap), 64'd0);
    busWrite(8'h14, 32'h0010_0000);
    readCheck("R8", 8'h14, 32'h0);
    readCheck("R8", 8'h10, 32'h0);
    busWrite(8'h00, 32'hFFDF_FFFF);
    snap = pulses;
    busWrite(8'h10, 32'h0020_0000);
    idle(3);
    check("R7", "masked line", 64'(pulses - snap), 64'd0);
    readCheck("R7", 8'h10, 32'h0020_0000);
    readCheck("R7", 8'h14, 32'h0);
    busWrite(8'h00, 32'hFFFF_FFFF);
    busWrite(8'h10, 32'h0);
    driveIn(0, 1'b1);
    readCheck("R7", 8'h14, 32'h1);
    snap = pulses;
    busWrite(8'h10, 32'h1);
    idle(3);
    check("R7", "pending line", 64'(pulses - snap), 64'd0);
    busWrite(8'h14, 32'h1);
    readCheck("R8", 8'h10, 32'h0);
    readCheck("R8", 8'h14, 32'h0);
  endtask

  task automatic t_bank1();
    int snap;
    busWrite(8'h30, 32'h0000_0008);
    check("R10", "bank1 pulse line35", 64'(irqOut), 64'h08_0000_0000);
    readCheck("R10", 8'h34, 32'h8);
    snap = pulses;
    busWrite(8'h30, 32'h0000_0080);
    idle(3);
    check("R3", "direct line no trigger", 64'(pulses - snap), 64'd0);
    readCheck("R3", 8'h30, 32'h0);
    readCheck("R10", 8'h34, 32'h8);
  endtask

  task automatic t_sameCycle();
    int snap;
    busWrite(8'h08, 32'h0000_0010);
    snap = pulses;
    @(negedge clk);
    extIn[4] = 1'b1;
    wrEn = 1'b1; addr = 8'h10; wrData = 32'h10;
    @(negedge clk);
    wrEn = 1'b0;
    check("R9", "joint pulse line4", 64'(irqOut), 64'h10);
    idle(3);
    check("R9", "single pulse", 64'(pulses - snap), 64'd1);
    readCheck("R9", 8'h14, 32'h10);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_masking();
    t_decode();
    t_hwEdge();
    t_maskGate();
    t_pendClear();
    t_swTrig();
    t_swBlock();
    t_bank1();
    t_sameCycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule